// File: doc/BRIEF.md
# Multi-Cycle Load/Store/Add Processor Sequencer

This block is a small processor core that runs each instruction over several clock cycles under a state-machine controller. It handles three instructions: a register add, a word load and a word store. It talks to one single-port synchronous word memory. That memory holds both the program and the data, and it returns read data one cycle after the address is presented.

Every instruction starts with a fetch state and a decode state. The opcode seen in decode then picks one of three paths. The add path has execute, memory and writeback steps. The load path has three steps. The store path has two steps. A debug port shows the program counter, the current state code and one register file entry chosen by a select input.

Top module: `mc_core`

## Requirements
- R1: While rst_ni is low, the state code is 0 (fetch), the program counter is 0, every register file entry reads 0 and mem_we_o is low.
- R2: Fetch (code 0) presents the program counter on mem_addr_o and always moves to decode (code 1). The program counter grows by exactly 4 across the fetch cycle and holds in every other state.
- R3: The opcode is instruction bits [31:26], and decode dispatches on it. Opcode 0 goes to code 7, opcode 35 goes to code 4 and opcode 43 goes to code 2. Any other opcode goes back to code 0. The state code never exceeds 9.
- R4: Add (opcode 0; rs [25:21], rt [20:16], rd [15:11]) visits codes 1, 7, 8, 9 and then 0. That is 5 cycles from fetch to the next fetch. Register rd receives (rs + rt) mod 2^32.
- R5: Load (opcode 35, rt destination, immediate [15:0]) visits codes 1, 4, 5, 6 and then 0, which is 5 cycles. Register rt receives the memory word at rs plus the sign-extended immediate.
- R6: Store (opcode 43) visits codes 1, 2, 3 and then 0, which is 4 cycles. Register rt is written to memory at rs plus the sign-extended immediate. mem_we_o is high for exactly one cycle, only in code 3, and only right after code 2.
- R7: Register 0 always reads 0. Writes to it from an add or a load are dropped.
- R8: An unsupported opcode takes 2 cycles. It changes no register and writes no memory. Only the program counter advances by 4.
- R9: dbg_reg_o shows, in the same cycle, the register file entry chosen by dbg_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 32 | Byte address to memory |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the address |
| dbg_pc_o | output | 32 | Program counter |
| dbg_state_o | output | 4 | Controller state code |
| dbg_sel_i | input | 5 | Register file entry to show |
| dbg_reg_o | output | 32 | Selected register file entry |

## Verification
A wrong next-state choice shows on dbg_state_o at the very next sampled cycle. It also changes the fetch-to-fetch cycle count of that instruction. A datapath fault, such as a bad sign extension, a swapped rt/rd destination or a dropped register-0 guard, does not appear until the writeback or store edge. From there it reaches memory or dbg_reg_o within one cycle. A program-counter fault shifts every later fetch, so the rest of the instruction stream then disagrees with the reference model.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [3:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_SW_ADDR = 4'd2,
    ST_SW_MEM  = 4'd3,
    ST_LW_ADDR = 4'd4,
    ST_LW_MEM  = 4'd5,
    ST_LW_WB   = 4'd6,
    ST_ADD_EX  = 4'd7,
    ST_ADD_MEM = 4'd8,
    ST_ADD_WB  = 4'd9
  } state_e;

  localparam logic [5:0] OP_ADD = 6'd0;
  localparam logic [5:0] OP_LW  = 6'd35;
  localparam logic [5:0] OP_SW  = 6'd43;

  typedef struct packed {
    logic pc_inc;
    logic ir_ld;
    logic ab_ld;
    logic alu_ld;
    logic alu_imm;
    logic rf_we;
    logic rf_dst_rt;
    logic rf_from_mem;
    logic mem_we;
    logic addr_alu;
  } ctrl_t;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] opcode_i,
  output state_e     state_o,
  output ctrl_t      ctrl_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = ST_FETCH;
    unique case (state_q)
      ST_FETCH:   state_d = ST_DECODE;
      ST_DECODE: begin
        if      (opcode_i == OP_ADD) state_d = ST_ADD_EX;
        else if (opcode_i == OP_LW)  state_d = ST_LW_ADDR;
        else if (opcode_i == OP_SW)  state_d = ST_SW_ADDR;
        else                         state_d = ST_FETCH;
      end
      ST_SW_ADDR: state_d = ST_SW_MEM;
      ST_SW_MEM:  state_d = ST_FETCH;
      ST_LW_ADDR: state_d = ST_LW_MEM;
      ST_LW_MEM:  state_d = ST_LW_WB;
      ST_LW_WB:   state_d = ST_FETCH;
      ST_ADD_EX:  state_d = ST_ADD_MEM;
      ST_ADD_MEM: state_d = ST_ADD_WB;
      ST_ADD_WB:  state_d = ST_FETCH;
      default:    state_d = ST_FETCH;
    endcase
  end

  always_comb begin
    ctrl_o = '0;
    case (state_q)
      ST_FETCH:  ctrl_o.pc_inc = 1'b1;
      ST_DECODE: begin
        ctrl_o.ir_ld = 1'b1;
        ctrl_o.ab_ld = 1'b1;
      end
      ST_SW_ADDR, ST_LW_ADDR: begin
        ctrl_o.alu_ld  = 1'b1;
        ctrl_o.alu_imm = 1'b1;
      end
      ST_SW_MEM: begin
        ctrl_o.mem_we   = 1'b1;
        ctrl_o.addr_alu = 1'b1;
      end
      // read issued here, data lands one cycle later in ST_LW_WB
      ST_LW_MEM: ctrl_o.addr_alu = 1'b1;
      ST_LW_WB: begin
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.rf_dst_rt   = 1'b1;
        ctrl_o.rf_from_mem = 1'b1;
      end
      ST_ADD_EX: ctrl_o.alu_ld = 1'b1;
      ST_ADD_WB: ctrl_o.rf_we  = 1'b1;
      default: ;
    endcase
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RA_W-1:0] ra_i,
  input  logic [RA_W-1:0] rb_i,
  input  logic [RA_W-1:0] rdbg_i,
  input  logic            we_i,
  input  logic [RA_W-1:0] wa_i,
  input  logic [XLEN-1:0] wd_i,
  output logic [XLEN-1:0] ra_o,
  output logic [XLEN-1:0] rb_o,
  output logic [XLEN-1:0] rdbg_o
);
  logic [XLEN-1:0] regs_w [NREG];

  assign regs_w[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && wa_i == RA_W'(i))   q <= wd_i;
    end
    assign regs_w[i] = q;
  end

  assign ra_o   = regs_w[ra_i];
  assign rb_o   = regs_w[rb_i];
  assign rdbg_o = regs_w[rdbg_i];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RA_W  = $clog2(NREG),
  localparam int IMM_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctrl_t           ctrl_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic [RA_W-1:0] dbg_sel_i,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic [XLEN-1:0] pc_o,
  output logic [5:0]      opcode_o,
  output logic [XLEN-1:0] dbg_reg_o
);
  logic [XLEN-1:0] pc_q, a_q, b_q, alu_q;
  logic [20:0]     ir_q;      // rt, rd and immediate fields only
  logic [XLEN-1:0] rf_a, rf_b, imm_sx, alu_rhs, rf_wd;
  logic [RA_W-1:0] dec_rs, dec_rt, ir_rt, ir_rd, rf_wa;

  // decode reads straight from the memory output register
  assign opcode_o = mem_rdata_i[31:26];
  assign dec_rs   = mem_rdata_i[21 +: RA_W];
  assign dec_rt   = mem_rdata_i[16 +: RA_W];

  assign ir_rt  = ir_q[16 +: RA_W];
  assign ir_rd  = ir_q[11 +: RA_W];
  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
    end else begin
      if (ctrl_i.pc_inc) pc_q  <= pc_q + XLEN'(4);
      if (ctrl_i.ir_ld)  ir_q  <= mem_rdata_i[20:0];
      if (ctrl_i.ab_ld) begin
        a_q <= rf_a;
        b_q <= rf_b;
      end
      if (ctrl_i.alu_ld) alu_q <= a_q + alu_rhs;
    end
  end

  assign alu_rhs = ctrl_i.alu_imm ? imm_sx : b_q;
  assign rf_wa   = ctrl_i.rf_dst_rt ? ir_rt : ir_rd;
  assign rf_wd   = ctrl_i.rf_from_mem ? mem_rdata_i : alu_q;

  mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (dec_rs),
    .rb_i   (dec_rt),
    .rdbg_i (dbg_sel_i),
    .we_i   (ctrl_i.rf_we),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd),
    .ra_o   (rf_a),
    .rb_o   (rf_b),
    .rdbg_o (dbg_reg_o)
  );

  assign mem_addr_o  = ctrl_i.addr_alu ? alu_q : pc_q;
  assign mem_wdata_o = b_q;
  assign pc_o        = pc_q;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_we_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] dbg_pc_o,
  output logic [3:0]      dbg_state_o,
  input  logic [RA_W-1:0] dbg_sel_i,
  output logic [XLEN-1:0] dbg_reg_o
);
  ctrl_t      ctrl;
  state_e     state;
  logic [5:0] opcode;

  mc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode),
    .state_o  (state),
    .ctrl_o   (ctrl)
  );

  mc_datapath #(.XLEN(XLEN), .NREG(NREG)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata_i),
    .dbg_sel_i   (dbg_sel_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pc_o        (dbg_pc_o),
    .opcode_o    (opcode),
    .dbg_reg_o   (dbg_reg_o)
  );

  assign mem_we_o    = ctrl.mem_we;
  assign dbg_state_o = state;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      state_i,
  input logic [XLEN-1:0] pc_i,
  input logic            mem_we_i
);
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i <= 4'd9); // R3
  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd0 |=> state_i == 4'd1); // R2
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd0 |=> pc_i == $past(pc_i) + XLEN'(4)); // R2
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != 4'd0 |=> $stable(pc_i)); // R2
  AST_DECODE_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd1 |=> (state_i == 4'd0 || state_i == 4'd2 ||
                         state_i == 4'd4 || state_i == 4'd7)); // R3
  AST_ADD_EX_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd7 |=> state_i == 4'd8); // R4
  AST_ADD_MEM_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd8 |=> state_i == 4'd9); // R4
  AST_ADD_WB_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd9 |=> state_i == 4'd0); // R4
  AST_LOAD_ADDR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd4 |=> state_i == 4'd5); // R5
  AST_LOAD_MEM_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd5 |=> state_i == 4'd6); // R5
  AST_LOAD_WB_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd6 |=> state_i == 4'd0); // R5
  AST_STORE_ADDR_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd2 |=> state_i == 4'd3); // R6
  AST_STORE_MEM_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 4'd3 |=> state_i == 4'd0); // R6
  AST_WE_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> $past(state_i) == 4'd2); // R6
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i); // R6
endmodule

bind mc_core mc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_i  (dbg_state_o),
  .pc_i     (dbg_pc_o),
  .mem_we_i (mem_we_o)
);

// File: tb/mc_core_test.sv
`timescale 1ns/1ps
module mc_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dbg_pc, dbg_reg;
  logic        mem_we;
  logic [3:0]  dbg_state;
  logic [4:0]  dbg_sel = '0;

  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];
  logic [31:0] ref_reg [32];
  logic [31:0] ref_pc;
  int errs = 0, checks = 0, cyc = 0;

  always #2.5 clk = ~clk;

  mc_core uut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .dbg_pc_o(dbg_pc),
    .dbg_state_o(dbg_state), .dbg_sel_i(dbg_sel), .dbg_reg_o(dbg_reg)
  );

  // synchronous single-port memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:2]];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_r(input int rs, input int rt, input int rd);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 11'd0};
  endfunction

  function automatic logic [31:0] mk_i(input logic [5:0] op, input int rs, input int rt,
                                       input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic read_reg(input int idx, output logic [31:0] val);
    dbg_sel = 5'(idx);
    #0.5;
    val = dbg_reg;
  endtask

  // called just after a negedge with state 0
  task automatic run_instr(input logic [31:0] ins);
    logic [5:0]  op;
    int          rs, rt, rd, n, we_cnt, exp_n, dst;
    int          seq [5];
    logic [31:0] ea, v;
    string       tag;
    op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    mem[ref_pc[9:2]] = ins;
    ref_mem[ref_pc[9:2]] = ins;
    ea  = ref_reg[rs] + sext(ins[15:0]);
    dst = -1;
    if (op == 6'd0) begin
      tag = "R4"; exp_n = 5; seq = '{1, 7, 8, 9, 0};
      dst = rd;
      if (rd != 0) ref_reg[rd] = ref_reg[rs] + ref_reg[rt];
    end else if (op == 6'd35) begin
      tag = "R5"; exp_n = 5; seq = '{1, 4, 5, 6, 0};
      dst = rt;
      if (rt != 0) ref_reg[rt] = ref_mem[ea[9:2]];
    end else if (op == 6'd43) begin
      tag = "R6"; exp_n = 4; seq = '{1, 2, 3, 0, 0};
      ref_mem[ea[9:2]] = ref_reg[rt];
    end else begin
      tag = "R8"; exp_n = 2; seq = '{1, 0, 0, 0, 0};
    end
    ref_pc = ref_pc + 32'd4;
    n = 0; we_cnt = 0;
    do begin
      @(negedge clk);
      n++;
      if (mem_we) we_cnt++;
      if (n == 1) chk("R2 decode after fetch", 32'(dbg_state), 32'd1);
      else if (n <= exp_n) chk({"R3 path state ", tag}, 32'(dbg_state), 32'(seq[n-1]));
    end while (dbg_state != 4'd0 && n < 20);
    chk({tag, " cycle count"}, 32'(n), 32'(exp_n));
    chk("R2 pc step", dbg_pc, ref_pc);
    chk({tag, " write enable pulses"}, 32'(we_cnt), (op == 6'd43) ? 32'd1 : 32'd0);
    if (dst >= 0) begin
      read_reg(dst, v);
      chk((dst == 0) ? "R7 r0 stays zero" : {tag, " dest reg"}, v, ref_reg[dst]);
    end
    if (op == 6'd43) chk("R6 stored word", mem[ea[9:2]], ref_mem[ea[9:2]]);
    if (tag == "R8") begin
      read_reg(rt, v); chk("R8 rt unchanged", v, ref_reg[rt]);
      read_reg(rd, v); chk("R8 rd unchanged", v, ref_reg[rd]);
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      mem[i] = (i >= 192) ? ($urandom % 4096) : 32'd0;
      ref_mem[i] = mem[i];
    end
    mem[192] = 32'd1020;        ref_mem[192] = 32'd1020;
    mem[194] = 32'hFFFF_FFF0;   ref_mem[194] = 32'hFFFF_FFF0;
    for (int i = 0; i < 32; i++) ref_reg[i] = '0;
    ref_pc = '0;

    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 32'(dbg_state), 32'd0);
    chk("R1 reset pc", dbg_pc, 32'd0);
    chk("R1 reset we", 32'(mem_we), 32'd0);
    read_reg(17, v); chk("R1 reset reg", v, 32'd0);
    chk("R2 fetch address", mem_addr, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    run_instr(mk_i(6'd35, 0, 5, 16'd768));          // r5 = 1020
    run_instr(mk_i(6'd35, 5, 6, 16'hFF04));         // negative offset -> 768
    run_instr(mk_r(5, 6, 7));                       // r7 = 2040
    run_instr(mk_i(6'd43, 0, 7, 16'd772));
    run_instr(mk_i(6'd35, 0, 8, 16'd772));          // r8 = 2040 read back
    run_instr(mk_r(5, 6, 0));                       // R7 add to r0
    run_instr(mk_i(6'd35, 0, 0, 16'd768));          // R7 load to r0
    run_instr(mk_i(6'd35, 0, 9, 16'd776));          // r9 = fffffff0
    run_instr(mk_r(9, 9, 10));                      // R4 wrap
    run_instr(mk_i(6'd2, 5, 6, 16'h3800));          // R8 unknown opcode
    run_instr(mk_i(6'd63, 9, 10, 16'h5000));        // R8 unknown opcode

    for (int k = 0; k < 130; k++) begin
      int kind, base, rt, tgt;
      logic [31:0] diff;
      logic [5:0]  op;
      kind = int'($urandom % 8);
      tgt  = 768 + int'($urandom % 64) * 4;
      base = int'($urandom % 32);
      rt   = int'($urandom % 32);
      diff = 32'(tgt) - ref_reg[base];
      if (!($signed(diff) >= -32768 && $signed(diff) <= 32767)) begin
        base = 0; diff = 32'(tgt);
      end
      if (kind < 3) run_instr(mk_r(int'($urandom % 32), rt, int'($urandom % 32)));
      else if (kind < 5) run_instr(mk_i(6'd35, base, rt, diff[15:0]));
      else if (kind < 7) run_instr(mk_i(6'd43, base, rt, diff[15:0]));
      else begin
        do op = 6'($urandom); while (op == 6'd0 || op == 6'd35 || op == 6'd43);
        run_instr(mk_i(op, base, rt, 16'($urandom)));
      end
    end

    for (int i = 0; i < 32; i++) begin
      read_reg(i, v);
      chk("R9 debug register view", v, ref_reg[i]);
    end
    for (int i = 192; i < 256; i++) chk("R6 data region", mem[i], ref_mem[i]);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule